// File: doc/BRIEF.md
# Pulse Accumulator with Status Flags

This block is the 16-bit pulse accumulator of a general-purpose timer. It watches one external input pin and works in one of two modes. In event mode it counts every edge of the chosen polarity. In gated mode the pin acts as a gate, and the counter advances on each pulse of a prescaled clock enable for as long as the gate is open. The pin passes through a synchronizer into the bus clock domain before any edge is detected.

Software reaches a control register, the counter and a flag register through a single-cycle register port. The flag register holds an overflow flag and an input flag. Each flag is cleared by writing a one to its bit, and each has its own interrupt output, gated by its own enable bit. An optional fast-clear setting drops both flags whenever software touches the counter.

The mode logic is a four-state machine. `ST_OFF` is entered whenever the enable bit is low. When enabled, `ST_EVENT` is entered if the gated bit is low. When the gated bit is high, `ST_GATE_CLOSED` is entered if the synchronized gate is inactive and `ST_GATE_OPEN` if it is active. The machine moves from `ST_GATE_CLOSED` to `ST_GATE_OPEN` when the gate turns active. It moves back when the gate turns inactive, and that transition is the gate's trailing edge. It moves between the event and gated states whenever the gated bit changes.

Top module: `pulse_accum`

## Requirements
- R1: After reset the control register, the counter and both flags read 0, and both interrupt outputs are low.
- R2: The address map is 0 = control, 1 = counter, 2 = flags, and 3 reads 0. The control register is 6 bits: bit0 enable, bit1 gated mode, bit2 rising polarity, bit3 overflow-interrupt enable, bit4 input-interrupt enable, bit5 fast clear. The control register and the counter can be written at any time and read back in the same cycle as combinational data. A counter write in the same cycle as an increment wins, and the written value is stored.
- R3: The overflow flag (flag bit 1) is set only when an increment takes the counter from 0xFFFF to 0x0000. Writing the counter never sets it.
- R4: A write to the flag register clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. A set event in the same cycle as a clear leaves the flag set. Bits 15 to 2 of the flag register read 0, and bit 0 is the input flag.
- R5: `irq_ovf` equals the overflow flag ANDed with control bit3. `irq_edge` equals the input flag ANDed with control bit4.
- R6: In event mode (bit0=1, bit1=0), each synchronized edge of the selected polarity (bit2=1 rising, bit2=0 falling) adds one to the counter and sets the input flag. Edges of the other polarity are ignored.
- R7: In gated mode (bit0=1, bit1=1), the gate is active high when bit2=0 and active low when bit2=1. The counter adds one on each `tick_en` cycle while the machine is in the gate-open state and the gate is still active. Ticks while the gate is inactive are ignored.
- R8: In gated mode, the gate's trailing edge sets the input flag and does not advance the counter.
- R9: With bit5 set, any read or write of the counter address clears both flags on the next edge, unless a set event occurs in the same cycle. With bit5 clear, counter accesses leave the flags alone.
- R10: A pin change takes effect on the counter at the third rising clock edge after the pin changes. Reads before that edge return the old count.
- R11: With bit0 low, pin activity and ticks change neither the counter nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| pa_pin | input | 1 | Asynchronous accumulator input pin |
| tick_en | input | 1 | Prescaled time base for gated mode |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_edge | output | 1 | Input-flag interrupt request |

## Verification
The hardest cases to reach from the ports are the collisions: a counter write or a flag clear landing in exactly the cycle when a synchronized pin edge takes effect. These cases depend on the three-register latency from the pin. The directed part of the stimulus changes the pin and then places the bus access on the third following cycle. It also preloads the counter just below its maximum to force a wrap. Long constrained-random runs then mix pin toggles, ticks, mode changes and bus accesses, and compare every read and every interrupt output against a cycle model kept in the bench.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    localparam int CTL_EN       = 0;
    localparam int CTL_GATED    = 1;
    localparam int CTL_RISE     = 2;
    localparam int CTL_OVF_IE   = 3;
    localparam int CTL_EDGE_IE  = 4;
    localparam int CTL_FAST_CLR = 5;
    localparam int CTL_W        = 6;

    localparam int FLG_EDGE = 0;
    localparam int FLG_OVF  = 1;
    localparam int FLG_N    = 2;

    localparam logic [1:0] ADDR_CTL = 2'd0;
    localparam logic [1:0] ADDR_CNT = 2'd1;
    localparam logic [1:0] ADDR_FLG = 2'd2;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_EVENT,
        ST_GATE_CLOSED,
        ST_GATE_OPEN
    } acc_state_e;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic sync_q,
    output logic dly_q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            dly_q <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            dly_q <= chain[STAGES-1];
        end
    end

    assign sync_q = chain[STAGES-1];
endmodule

// File: rtl/pacc_mode_fsm.sv
module pacc_mode_fsm
    import pacc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic gated,
    input  logic rise,
    input  logic sync_q,
    input  logic dly_q,
    input  logic tick,
    output logic inc,
    output logic evt
);
    acc_state_e state, nxt;
    logic lvl, act_edge;

    assign lvl      = sync_q ^ rise;
    assign act_edge = rise ? (sync_q & ~dly_q) : (~sync_q & dly_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF: begin
                if (en) nxt = gated ? (lvl ? ST_GATE_OPEN : ST_GATE_CLOSED) : ST_EVENT;
            end
            ST_EVENT: begin
                if (!en)        nxt = ST_OFF;
                else if (gated) nxt = lvl ? ST_GATE_OPEN : ST_GATE_CLOSED;
            end
            ST_GATE_CLOSED: begin
                if (!en)         nxt = ST_OFF;
                else if (!gated) nxt = ST_EVENT;
                else if (lvl)    nxt = ST_GATE_OPEN;
            end
            ST_GATE_OPEN: begin
                if (!en)         nxt = ST_OFF;
                else if (!gated) nxt = ST_EVENT;
                else if (!lvl)   nxt = ST_GATE_CLOSED;
            end
            default: nxt = ST_OFF;
        endcase
    end

    always_comb begin
        inc = 1'b0;
        evt = 1'b0;
        unique case (state)
            ST_EVENT: begin
                inc = act_edge;
                evt = act_edge;
            end
            ST_GATE_OPEN: begin
                inc = tick & lvl;
                evt = ~lvl;
            end
            default: begin
                inc = 1'b0;
                evt = 1'b0;
            end
        endcase
    end

    AST_OFF_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en)) |-> (!inc && !evt)); // R11
endmodule

// File: rtl/pacc_flags.sv
module pacc_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_wr,
    input  logic [N-1:0] mask,
    input  logic         clr_all,
    output logic [N-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            for (int i = 0; i < N; i++)
                q[i] <= set[i] | (q[i] & ~(clr_all | (clr_wr & mask[i])));
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && mask[g] && !set[g]) |=> !q[g]); // R4
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> q[g]); // R4
    end

    AST_FAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && (set == '0)) |=> (q == '0)); // R9
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
    import pacc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pa_pin,
    input  logic              tick_en,
    output logic              irq_ovf,
    output logic              irq_edge
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CTL_W-1:0] ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [FLG_N-1:0] flg_q, flg_set;
    logic ctl_wr, cnt_wr, cnt_acc, flg_wr;
    logic pin_s, pin_d, inc, evt;

    assign ctl_wr  = bus_sel & bus_wr & (bus_addr == ADDR_CTL);
    assign cnt_wr  = bus_sel & bus_wr & (bus_addr == ADDR_CNT);
    assign cnt_acc = bus_sel & (bus_addr == ADDR_CNT);
    assign flg_wr  = bus_sel & bus_wr & (bus_addr == ADDR_FLG);

    pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (pa_pin),
        .sync_q (pin_s),
        .dly_q  (pin_d)
    );

    pacc_mode_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctl_q[CTL_EN]),
        .gated  (ctl_q[CTL_GATED]),
        .rise   (ctl_q[CTL_RISE]),
        .sync_q (pin_s),
        .dly_q  (pin_d),
        .tick   (tick_en),
        .inc    (inc),
        .evt    (evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= bus_wdata[CTL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_wr) cnt_q <= bus_wdata[CNT_W-1:0];
        else if (inc)    cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        flg_set           = '0;
        flg_set[FLG_OVF]  = inc & ~cnt_wr & (cnt_q == CNT_MAX);
        flg_set[FLG_EDGE] = evt;
    end

    pacc_flags #(.N(FLG_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (flg_set),
        .clr_wr  (flg_wr),
        .mask    (bus_wdata[FLG_N-1:0]),
        .clr_all (cnt_acc & ctl_q[CTL_FAST_CLR]),
        .q       (flg_q)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTL: bus_rdata[CTL_W-1:0] = ctl_q;
            ADDR_CNT: bus_rdata[CNT_W-1:0] = cnt_q;
            ADDR_FLG: bus_rdata[FLG_N-1:0] = flg_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_ovf  = flg_q[FLG_OVF]  & ctl_q[CTL_OVF_IE];
    assign irq_edge = flg_q[FLG_EDGE] & ctl_q[CTL_EDGE_IE];

    AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(bus_wdata[CNT_W-1:0]))); // R2
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6
    AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !cnt_wr && cnt_q == CNT_MAX) |=> (flg_q[FLG_OVF] && cnt_q == '0)); // R3
endmodule

// File: tb/test_pulse_accum.sv
module test_pulse_accum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic        pa_pin = 1'b0, tick_en = 1'b0;
    logic [15:0] bus_rdata;
    logic        irq_ovf, irq_edge;

    logic drive_pin = 1'b0, drive_tick = 1'b0;
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pulse_accum i_pulse_accum (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_pin(pa_pin), .tick_en(tick_en), .irq_ovf(irq_ovf), .irq_edge(irq_edge)
    );

    // Cycle model built from the requirements
    logic [15:0] m_cnt;
    logic [5:0]  m_ctl;
    logic        m_ovf, m_edge, m_s1, m_s2, m_s3;
    int          m_st; // 0 off, 1 event, 2 gate closed, 3 gate open

    function automatic int f_next(int st, logic en, logic gated, logic lvl);
        if (!en) return 0;
        if (!gated) return 1;
        return lvl ? 3 : 2;
    endfunction

    function automatic logic [15:0] f_read(logic [1:0] a);
        case (a)
            2'd0:    return {10'd0, m_ctl};
            2'd1:    return m_cnt;
            2'd2:    return {14'd0, m_ovf, m_edge};
            default: return 16'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin : mdl
        logic lvl, edg, inc, evt, cwr, ovf_set;
        logic [1:0] clrm;
        if (!rst_n) begin
            m_cnt = 0; m_ctl = 0; m_ovf = 0; m_edge = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_st = 0;
        end else begin
            lvl = m_s2 ^ m_ctl[2];
            edg = m_ctl[2] ? (m_s2 && !m_s3) : (!m_s2 && m_s3);
            inc = 0; evt = 0;
            if (m_st == 1) begin inc = edg; evt = edg; end
            else if (m_st == 3) begin inc = tick_en && lvl; evt = !lvl; end
            cwr = bus_sel && bus_wr && bus_addr == 2'd1;
            ovf_set = inc && !cwr && m_cnt == 16'hFFFF;
            clrm = (bus_sel && bus_wr && bus_addr == 2'd2) ? bus_wdata[1:0] : 2'b00;
            if (m_ctl[5] && bus_sel && bus_addr == 2'd1) clrm = 2'b11;
            m_ovf  = ovf_set | (m_ovf & !clrm[1]);
            m_edge = evt | (m_edge & !clrm[0]);
            if (cwr) m_cnt = bus_wdata;
            else if (inc) m_cnt = m_cnt + 16'd1;
            m_st = f_next(m_st, m_ctl[0], m_ctl[1], lvl);
            if (bus_sel && bus_wr && bus_addr == 2'd0) m_ctl = bus_wdata[5:0];
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pa_pin;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic sel, input logic wr, input logic [1:0] a,
                       input logic [15:0] wd, input string tag);
        @(negedge clk);
        chk("R5", {14'd0, irq_ovf, irq_edge}, {14'd0, m_ovf & m_ctl[3], m_edge & m_ctl[4]});
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        pa_pin = drive_pin; tick_en = drive_tick;
        #1;
        if (sel && !wr) chk(tag, bus_rdata, f_read(a));
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        cyc(1'b1, 1'b0, a, 16'd0, tag);
    endtask
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        cyc(1'b1, 1'b1, a, d, "");
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 16'd0, "");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1");
        // R2 read/write of counter and control
        wr(2'd1, 16'h1234); rd(2'd1, "R2");
        wr(2'd0, 16'h0038); rd(2'd0, "R2"); rd(2'd3, "R2");
        wr(2'd0, 16'h0000);
        // R6 / R10 event mode, rising edges, latency
        wr(2'd0, 16'h0005); idle(4);
        drive_pin = 1; rd(2'd1, "R10"); rd(2'd1, "R10"); rd(2'd1, "R10"); rd(2'd1, "R10");
        rd(2'd2, "R6");
        drive_pin = 0; idle(4); rd(2'd1, "R6");
        wr(2'd0, 16'h0001); drive_pin = 1; idle(4); drive_pin = 0; idle(4); rd(2'd1, "R6");
        // R2 counter write beats coincident increment
        wr(2'd0, 16'h0005); idle(3);
        drive_pin = 1; idle(2); wr(2'd1, 16'hABCD); rd(2'd1, "R2");
        // R4 set wins over clear in the same cycle
        drive_pin = 0; idle(4); wr(2'd2, 16'h0003);
        drive_pin = 1; idle(2); wr(2'd2, 16'h0001); rd(2'd2, "R4");
        // R3 wrap sets overflow
        drive_pin = 0; wr(2'd0, 16'h000D); wr(2'd1, 16'hFFFE); idle(4);
        drive_pin = 1; idle(4); drive_pin = 0; idle(4); drive_pin = 1; idle(4);
        rd(2'd1, "R3"); rd(2'd2, "R3");
        wr(2'd2, 16'h0000); rd(2'd2, "R4");
        wr(2'd2, 16'h0002); rd(2'd2, "R4");
        wr(2'd2, 16'h0003); wr(2'd1, 16'hFFFF); wr(2'd1, 16'h0000); rd(2'd2, "R3");
        // R7 / R8 gated mode, active-high gate
        drive_pin = 0; wr(2'd0, 16'h0013); idle(4);
        drive_tick = 1; drive_pin = 1; idle(10); rd(2'd1, "R7");
        drive_pin = 0; idle(5); rd(2'd1, "R7"); rd(2'd2, "R8");
        drive_pin = 1; drive_tick = 0; idle(6); rd(2'd1, "R7");
        drive_tick = 1; idle(3); drive_pin = 0; idle(5); rd(2'd1, "R8"); rd(2'd2, "R8");
        // R9 fast clear
        wr(2'd0, 16'h0033); rd(2'd2, "R9"); rd(2'd1, "R9"); rd(2'd2, "R9");
        wr(2'd0, 16'h0013); drive_pin = 1; idle(4); drive_pin = 0; idle(4);
        rd(2'd1, "R9"); rd(2'd2, "R9");
        // R11 disabled
        wr(2'd2, 16'h0003); wr(2'd0, 16'h0004);
        drive_pin = 1; idle(4); drive_pin = 0; idle(4); rd(2'd1, "R11"); rd(2'd2, "R11");
        // constrained random mix
        for (int i = 0; i < 6000; i++) begin
            logic [1:0] a;
            if ($urandom_range(0, 3) == 0) drive_pin = ~drive_pin;
            drive_tick = $urandom_range(0, 1) == 1;
            a = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 0) idle(1);
            else if (a == 2'd0 && $urandom_range(0, 7) == 0)
                wr(2'd0, {10'd0, 6'($urandom_range(0, 63)) | 6'd1});
            else if (a == 2'd1 && $urandom_range(0, 7) == 0)
                wr(2'd1, ($urandom_range(0, 1) == 1) ? 16'hFFFD : 16'($urandom));
            else if (a == 2'd2 && $urandom_range(0, 3) == 0)
                wr(2'd2, 16'($urandom_range(0, 3)));
            else
                rd(a, a == 2'd1 ? "R6" : (a == 2'd2 ? "R4" : "R2"));
        end
        idle(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule